// File: doc/BRIEF.md
# External Trigger Timestamp Capture Unit

This block watches two asynchronous trigger pins. Each pin passes through a synchroniser and an edge detector. When the edge chosen for that pin arrives, the block copies the free-running 64-bit time value into that pin's timestamp register pair. The pair has a high word and a low word. The time value comes from a counter elsewhere in the chip.

The same block also holds the event register for all timer events. Events from the neighbouring alarm and pulse logic arrive as one-cycle pulses on `evtIn`. Trigger captures raise their own bits. Software acknowledges an event by writing a one to its bit. A mask register with the same bit layout decides which events drive the single registered interrupt line.

Software reads a timestamp high word first. That read also freezes the matching low word in a shadow register. The low word read that follows therefore belongs to the same capture, even if a new trigger edge lands between the two reads.

Top module: `ptpTrigCapture`

## Requirements
- R1: After reset, the control, event and mask registers, all four timestamp words, `rdData` and `irq` read as zero.
- R2: Each trigger pin passes through a two-flop synchroniser and then an edge detector. A change applied before clock edge k is captured at edge k+2, and the event bit is visible from then on.
- R3: Register 0 (control) selects the capture edge: bit 8 for trigger 1 and bit 9 for trigger 2. A value of 0 selects the rising edge and 1 the falling edge. The opposite edge captures nothing and raises no event.
- R4: A capture stores time bits 63:32 and 31:0 in the pin's own pair. Trigger 1 uses register 3 (high) and register 4 (low). Trigger 2 uses register 5 (high) and register 6 (low).
- R5: A capture on trigger 1 sets event bit 24, and a capture on trigger 2 sets event bit 25. The event register is register 1.
- R6: Writing register 1 clears every event bit written as one. Bits written as zero keep their value.
- R7: When a new event and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: A capture while the pin's event bit is still set overwrites the stored timestamp with the new time.
- R9: Register 2 is the mask. `irq` is a register that holds the OR over all bits of (event AND mask), one cycle after the event state.
- R10: Reading a high word copies the matching low word into a shadow register. Reading the low word returns that shadow value.
- R11: A pulse on `evtIn` sets the matching event bit. Pulses at bits 24 and 25 are ignored, because those bits belong to the triggers.
- R12: `rdData` shows the addressed register on the cycle after the clock edge that sampled `rdEn`. It holds that value while `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNow | input | 64 | Current time from the time counter |
| trigIn | input | 2 | Asynchronous trigger pins (bit 0 = trigger 1) |
| evtIn | input | 32 | One-cycle event pulses from other timer logic |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register index |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench places a clear in the exact cycle that a capture sets the same bit. A design where the clear wins would lose that event. The bench also counts the cycles from a pin change to the interrupt. A synchroniser that is one stage short, or an interrupt that is not registered, would raise the line a cycle early.

Each pin is driven through both edges under both polarity settings. A design that swaps the polarity sense, or mixes up the two pins' control bits, would capture on the wrong edge.

The bench also lets a second capture land between a high read and the low read that follows it. A design without the shadow would return a torn timestamp. Finally, `evtIn` pulses are sent at the trigger bit positions. Those must leave the event register unchanged.

// File: rtl/ptpTrigPkg.sv
package ptpTrigPkg;
  localparam int TRIG_N       = 2;
  localparam int DATA_W       = 32;
  localparam int TIME_W       = 64;
  localparam int ADDR_W       = 3;
  localparam int TRIG_EVT_LSB = 24;
  localparam int CTRL_POL_LSB = 8;
  localparam int TS_BASE      = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_EVENT = 3'd1,
    REG_MASK  = 3'd2
  } regAddrE;

  typedef struct packed {
    logic [TRIG_N-1:0] capture;
    logic              wrCtrl;
    logic              wrEvent;
    logic              wrMask;
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
  } strobeT;
endpackage

// File: rtl/ptpTrigCtrl.sv
module ptpTrigCtrl
  import ptpTrigPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TRIG_N-1:0] trigIn,
  input  logic [TRIG_N-1:0] edgeFalling,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobeT            strobes
);
  logic [TRIG_N-1:0] capVec;

  for (genvar g = 0; g < TRIG_N; g++) begin : gTrig
    logic [SYNC_STAGES-1:0] shiftQ;
    logic                   prevQ;
    logic                   level;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shiftQ <= '0;
        prevQ  <= 1'b0;
      end else begin
        shiftQ <= {shiftQ[SYNC_STAGES-2:0], trigIn[g]};
        prevQ  <= shiftQ[SYNC_STAGES-1];
      end
    end

    assign level     = shiftQ[SYNC_STAGES-1];
    assign capVec[g] = edgeFalling[g] ? (prevQ & ~level) : (~prevQ & level);

    // R2
    cap_single_chk: assert property (@(posedge clk) disable iff (!rstN)
      capVec[g] |=> !capVec[g]);
  end

  always_comb begin
    strobes         = '0;
    strobes.capture = capVec;
    strobes.wrCtrl  = wrEn && (addr == REG_CTRL);
    strobes.wrEvent = wrEn && (addr == REG_EVENT);
    strobes.wrMask  = wrEn && (addr == REG_MASK);
    strobes.rdEn    = rdEn;
    strobes.rdAddr  = addr;
  end
endmodule

// File: rtl/ptpTrigDp.sv
module ptpTrigDp
  import ptpTrigPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [TIME_W-1:0] timeNow,
  input  logic [DATA_W-1:0] evtIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [TRIG_N-1:0] edgeFalling,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam logic [DATA_W-1:0] TRIG_BITS =
    DATA_W'(((1 << TRIG_N) - 1) << TRIG_EVT_LSB);

  logic [TRIG_N-1:0] polQ;
  logic [DATA_W-1:0] evtQ, maskQ, evtNext, trigEvt, clrMask, rdQ;
  logic [DATA_W-1:0] tsHiQ [TRIG_N];
  logic [DATA_W-1:0] tsLoQ [TRIG_N];
  logic [DATA_W-1:0] loShadowQ [TRIG_N];
  logic              irqQ;

  always_comb begin
    trigEvt = '0;
    for (int i = 0; i < TRIG_N; i++) trigEvt[TRIG_EVT_LSB+i] = strobes.capture[i];
    clrMask = strobes.wrEvent ? wrData : '0;
    evtNext = (evtQ & ~clrMask) | (evtIn & ~TRIG_BITS) | trigEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polQ  <= '0;
      evtQ  <= '0;
      maskQ <= '0;
      irqQ  <= 1'b0;
      for (int i = 0; i < TRIG_N; i++) begin
        tsHiQ[i] <= '0;
        tsLoQ[i] <= '0;
      end
    end else begin
      evtQ <= evtNext;
      irqQ <= |(evtQ & maskQ);
      if (strobes.wrMask) maskQ <= wrData;
      if (strobes.wrCtrl) polQ <= wrData[CTRL_POL_LSB +: TRIG_N];
      for (int i = 0; i < TRIG_N; i++) begin
        if (strobes.capture[i]) begin
          tsHiQ[i] <= timeNow[TIME_W-1:DATA_W];
          tsLoQ[i] <= timeNow[DATA_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
      for (int i = 0; i < TRIG_N; i++) loShadowQ[i] <= '0;
    end else if (strobes.rdEn) begin
      rdQ <= '0;
      case (strobes.rdAddr)
        REG_CTRL:  rdQ[CTRL_POL_LSB +: TRIG_N] <= polQ;
        REG_EVENT: rdQ <= evtQ;
        REG_MASK:  rdQ <= maskQ;
        default: ;
      endcase
      for (int i = 0; i < TRIG_N; i++) begin
        if (strobes.rdAddr == ADDR_W'(TS_BASE + 2 * i)) begin
          rdQ          <= tsHiQ[i];
          loShadowQ[i] <= tsLoQ[i];
        end
        if (strobes.rdAddr == ADDR_W'(TS_BASE + 2 * i + 1)) rdQ <= loShadowQ[i];
      end
    end
  end

  assign edgeFalling = polQ;
  assign rdData      = rdQ;
  assign irq         = irqQ;

  // R4
  ts_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture[0] |=> ({tsHiQ[0], tsLoQ[0]} == $past(timeNow)));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture[0] |=> evtQ[TRIG_EVT_LSB]);

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEvent && wrData[TRIG_EVT_LSB+1] && !strobes.capture[1])
      |=> !evtQ[TRIG_EVT_LSB+1]);

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |=> !irqQ);
endmodule

// File: rtl/ptpTrigCapture.sv
module ptpTrigCapture
  import ptpTrigPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] timeNow,
  input  logic [TRIG_N-1:0] trigIn,
  input  logic [DATA_W-1:0] evtIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  strobeT            strobes;
  logic [TRIG_N-1:0] edgeFalling;

  ptpTrigCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .edgeFalling(edgeFalling),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strobes(strobes)
  );

  ptpTrigDp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .timeNow(timeNow),
    .evtIn(evtIn), .wrData(wrData), .edgeFalling(edgeFalling),
    .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/ptpTrigCapture_bench.sv
module ptpTrigCapture_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] timeNow = '0;
  logic [1:0]  trigIn = '0;
  logic [31:0] evtIn = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ptpTrigCapture u_ptpTrigCapture (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .trigIn(trigIn), .evtIn(evtIn),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  typedef struct packed {
    logic        idx;
    logic        pol;
    logic        lvl;
    logic [63:0] t;
    logic        expCap;
  } vecT;

  localparam vecT VECS [8] = '{
    '{1'b0, 1'b0, 1'b1, 64'h0000_0011_0000_0101, 1'b1},
    '{1'b0, 1'b0, 1'b0, 64'h0000_0012_0000_0102, 1'b0},
    '{1'b1, 1'b1, 1'b1, 64'h0000_0013_0000_0103, 1'b0},
    '{1'b1, 1'b1, 1'b0, 64'h0000_0014_0000_0104, 1'b1},
    '{1'b0, 1'b1, 1'b1, 64'h0000_0015_0000_0105, 1'b0},
    '{1'b0, 1'b1, 1'b0, 64'h0000_0016_0000_0106, 1'b1},
    '{1'b1, 1'b0, 1'b1, 64'h0000_0017_0000_0107, 1'b1},
    '{1'b1, 1'b0, 1'b0, 64'h0000_0018_0000_0108, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rdData", rdData, 32'd0);
    regRead(3'd1, v); chk("R1 event", v, 32'd0);
    regRead(3'd2, v); chk("R1 mask", v, 32'd0);
    regRead(3'd0, v); chk("R1 ctrl", v, 32'd0);
    regRead(3'd5, v); chk("R1 ts2 hi", v, 32'd0);
    regRead(3'd6, v); chk("R1 ts2 lo", v, 32'd0);

    // R3 R4 R5 table of edges and polarities
    foreach (VECS[k]) begin
      regWrite(3'd0, 32'(VECS[k].pol) << (8 + VECS[k].idx));
      idle(4);
      regWrite(3'd1, 32'hFFFF_FFFF);
      timeNow = VECS[k].t;
      trigIn[VECS[k].idx] = VECS[k].lvl;
      idle(5);
      regRead(3'd1, v);
      chk("R3/R5 event", v, VECS[k].expCap ? (32'd1 << (24 + VECS[k].idx)) : 32'd0);
      if (VECS[k].expCap) begin
        regRead(3'(3 + 2 * VECS[k].idx), v); chk("R4 hi", v, VECS[k].t[63:32]);
        regRead(3'(4 + 2 * VECS[k].idx), v); chk("R4 lo", v, VECS[k].t[31:0]);
      end
    end
    regRead(3'd0, v); chk("R12 ctrl readback", v, 32'd0);

    // R2 R9 latency: pin change, capture, then registered irq
    regWrite(3'd1, 32'hFFFF_FFFF);
    regWrite(3'd2, 32'h0100_0000);
    timeNow = 64'h0000_00AA_0000_00BB;
    @(negedge clk); trigIn[0] = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R2 irq not early", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R9 irq one after capture", {31'd0, irq}, 32'd1);

    // R9 masking
    regWrite(3'd2, 32'h0);
    idle(2);
    chk("R9 masked irq low", {31'd0, irq}, 32'd0);

    // R8 overwrite while event still set
    trigIn[0] = 1'b0; idle(4);
    timeNow = 64'h0000_00CC_0000_00DD;
    trigIn[0] = 1'b1; idle(5);
    regRead(3'd3, v); chk("R8 overwrite hi", v, 32'h0000_00CC);
    regRead(3'd4, v); chk("R8 overwrite lo", v, 32'h0000_00DD);

    // R7 clear and new capture on the same edge
    trigIn[0] = 1'b0; idle(4);
    regRead(3'd1, v); chk("R7 precondition", v & 32'h0100_0000, 32'h0100_0000);
    @(negedge clk); trigIn[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; addr = 3'd1; wrData = 32'h0100_0000;
    @(negedge clk); wrEn = 1'b0;
    regRead(3'd1, v); chk("R7 set wins", v & 32'h0100_0000, 32'h0100_0000);

    // R6 clear only written ones
    @(negedge clk); evtIn = 32'h0000_0009;
    @(negedge clk); evtIn = 32'h0;
    regWrite(3'd1, 32'h0100_0001);
    regRead(3'd1, v); chk("R6 w1c", v, 32'h0000_0008);

    // R11 external events, trigger positions ignored
    regWrite(3'd1, 32'hFFFF_FFFF);
    @(negedge clk); evtIn = 32'h0300_0040;
    @(negedge clk); evtIn = 32'h0;
    regRead(3'd1, v); chk("R11 evtIn", v, 32'h0000_0040);

    // R10 shadowed low word
    trigIn[1] = 1'b0; regWrite(3'd0, 32'h0); idle(4);
    timeNow = 64'h0000_1111_0000_2222;
    trigIn[1] = 1'b1; idle(5);
    regRead(3'd5, v); chk("R10 hi first", v, 32'h0000_1111);
    trigIn[1] = 1'b0; idle(4);
    timeNow = 64'h0000_3333_0000_4444;
    trigIn[1] = 1'b1; idle(5);
    regRead(3'd6, v); chk("R10 lo from shadow", v, 32'h0000_2222);
    regRead(3'd5, v); chk("R10 next hi", v, 32'h0000_3333);
    regRead(3'd6, v); chk("R10 next lo", v, 32'h0000_4444);

    // R12 rdData holds while rdEn low
    idle(3);
    chk("R12 hold", rdData, 32'h0000_4444);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule